// File: doc/BRIEF.md
# Aperture-Based Address Remapper

This block translates bus-master addresses into a target-slave choice and a rewritten address. Each master's 32-bit address space is cut into sixteen equal 256 MB apertures, picked by the top address nibble. Every aperture carries two 4-bit codes:

- A slave-select code, which names the target slave.
- An offset code, which replaces the top nibble of the outgoing address.

A select code of zero marks an aperture that reaches no target. Such an access is flagged as a decode error.

Software programs the maps through a simple word-wide register port. Each master owns a small bank of shadow registers. Writes only touch that shadow copy. Lookups always use a separate active copy. A shared update register copies the selected shadow tables into their active tables in one cycle, so several masters can switch maps at the same instant. Each master has its own lookup port. The routing result is registered, so it appears one clock after the request.

Top module: `addr_remap`

## Requirements
- R1: For a request on master m, the aperture is req_addr_i[m][31:28]. One clock later, rsp_addr_o[m] equals {offset code of that aperture, req_addr_i[m][27:0]}.
- R2: The bank of master m sits at byte address 0x10*m. The word at +0x0 holds the select codes of apertures 0..7 and the word at +0x4 holds apertures 8..15, with aperture i (mod 8) in bits [4i+3:4i]. The words at +0x8 and +0xC hold the offset codes in the same packing.
- R3: Select code 0 gives rsp_err_o=1, rsp_vld_o=0 and rsp_sel_o=0. A nonzero code gives rsp_vld_o=1, rsp_err_o=0 and rsp_sel_o equal to that code.
- R4: Register writes change only the shadow table. Lookups keep using the active table until that master is committed.
- R5: A write to byte address 0x100 copies the shadow into the active table of every master i whose bit i is set, all in the same cycle. Bits at or above NUM_MST are ignored.
- R6: A request presented in the same cycle as a commit is translated with the active table from before the commit.
- R7: After reset, both tables are zero, so every request is a decode error and all outputs are low until a request arrives.
- R8: Reads return the shadow word. Reads of 0x100, and of any address outside the master banks, return 0. Writes to such addresses change no bank.
- R9: A cycle with no request gives rsp_vld_o=0 and rsp_err_o=0 on the next cycle.
- R10: The masters translate independently, each through its own table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 9 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| req_valid_i | input | NUM_MST | Per-master request valid |
| req_addr_i | input | NUM_MST x 32 | Per-master request address |
| rsp_vld_o | output | NUM_MST | Routed to a slave |
| rsp_err_o | output | NUM_MST | Decode error (select code 0) |
| rsp_sel_o | output | NUM_MST x 4 | Target slave select code |
| rsp_addr_o | output | NUM_MST x 32 | Translated address |

## Verification
All sixteen apertures of all four masters are swept after each phase: freshly reset, programmed but not committed, partly committed through a mask with bits beyond the master count, fully committed, and reprogrammed. These sweeps separate shadow from active storage and one master's table from another's. Select and offset codes come from different arithmetic formulas per master, with zero select codes mixed in, so a swapped nibble, word or master, or a lost error flag, gives a wrong code. The low address bits differ for every master and aperture, which exposes any corruption of the passed-through bits. Separate directed cases cover a request in the commit cycle, readback of every bank word, and reads and writes at unmapped addresses.

// File: rtl/addr_remap_pkg.sv
package addr_remap_pkg;
  localparam int AP_NUM   = 16;
  localparam int CODE_W   = 4;
  localparam int WORDS    = 4;
  localparam int REG_AW   = 9;
  localparam int BANK_LSB = 4;
  localparam logic [REG_AW-1:0] UPD_ADDR = 9'h100;
  typedef logic [31:0] word_t;
  typedef logic [WORDS-1:0][31:0] table_t;
endpackage

// File: rtl/remap_bank.sv
module remap_bank
  import addr_remap_pkg::*;
#(
  parameter int MST_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  word_t             wdata_i,
  input  logic              commit_i,
  output word_t             rdata_o,
  output table_t            act_o
);
  localparam int IDX_W = REG_AW - BANK_LSB;

  table_t shadow_q, active_q;
  logic   hit;

  assign hit = (addr_i < UPD_ADDR) &&
               (addr_i[REG_AW-1:BANK_LSB] == IDX_W'(MST_ID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (we_i && hit) shadow_q[addr_i[3:2]] <= wdata_i;
      if (commit_i)    active_q <= shadow_q;
    end
  end

  assign rdata_o = hit ? shadow_q[addr_i[3:2]] : '0;
  assign act_o   = active_q;

  assert_commit_copies_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> active_q == $past(shadow_q));
  assert_active_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(active_q));
  assert_foreign_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> $stable(shadow_q));
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup
  import addr_remap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  table_t            act_i,
  input  logic              req_valid_i,
  input  word_t             req_addr_i,
  output logic              vld_o,
  output logic              err_o,
  output logic [CODE_W-1:0] sel_o,
  output word_t             addr_o
);
  logic [3:0]        ap;
  word_t             sel_word, off_word;
  logic [CODE_W-1:0] sel_c, off_c;

  assign ap       = req_addr_i[31:28];
  assign sel_word = act_i[ap[3] ? 2'd1 : 2'd0];
  assign off_word = act_i[ap[3] ? 2'd3 : 2'd2];
  assign sel_c    = sel_word[{ap[2:0], 2'b00} +: CODE_W];
  assign off_c    = off_word[{ap[2:0], 2'b00} +: CODE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      err_o  <= 1'b0;
      sel_o  <= '0;
      addr_o <= '0;
    end else begin
      vld_o  <= req_valid_i && (sel_c != '0);
      err_o  <= req_valid_i && (sel_c == '0);
      sel_o  <= req_valid_i ? sel_c : '0;
      addr_o <= req_valid_i ? {off_c, req_addr_i[27:0]} : '0;
    end
  end

  assert_one_outcome_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (vld_o != err_o));
  assert_err_no_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> sel_o == '0);
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!vld_o && !err_o));
  assert_low_bits_kept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> addr_o[27:0] == $past(req_addr_i[27:0]));
endmodule

// File: rtl/addr_remap.sv
module addr_remap
  import addr_remap_pkg::*;
#(
  parameter int NUM_MST = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            reg_we_i,
  input  logic [REG_AW-1:0]               reg_addr_i,
  input  logic [31:0]                     reg_wdata_i,
  output logic [31:0]                     reg_rdata_o,
  input  logic [NUM_MST-1:0]              req_valid_i,
  input  logic [NUM_MST-1:0][31:0]        req_addr_i,
  output logic [NUM_MST-1:0]              rsp_vld_o,
  output logic [NUM_MST-1:0]              rsp_err_o,
  output logic [NUM_MST-1:0][CODE_W-1:0]  rsp_sel_o,
  output logic [NUM_MST-1:0][31:0]        rsp_addr_o
);
  logic                     upd_wr;
  logic [NUM_MST-1:0]       commit;
  word_t  [NUM_MST-1:0]     bank_rd;
  table_t [NUM_MST-1:0]     act;

  assign upd_wr = reg_we_i && (reg_addr_i == UPD_ADDR);

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    assign commit[m] = upd_wr && reg_wdata_i[m];

    remap_bank #(.MST_ID(m)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (reg_we_i),
      .addr_i   (reg_addr_i),
      .wdata_i  (reg_wdata_i),
      .commit_i (commit[m]),
      .rdata_o  (bank_rd[m]),
      .act_o    (act[m])
    );

    remap_lookup u_lookup (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .act_i       (act[m]),
      .req_valid_i (req_valid_i[m]),
      .req_addr_i  (req_addr_i[m]),
      .vld_o       (rsp_vld_o[m]),
      .err_o       (rsp_err_o[m]),
      .sel_o       (rsp_sel_o[m]),
      .addr_o      (rsp_addr_o[m])
    );
  end

  // banks drive zero when not addressed
  always_comb begin
    reg_rdata_o = '0;
    for (int m = 0; m < NUM_MST; m++) reg_rdata_o |= bank_rd[m];
  end

  assert_upd_reads_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == UPD_ADDR) |-> reg_rdata_o == '0);
endmodule

// File: tb/addr_remap_bench.sv
module addr_remap_bench;
  localparam int NM = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_we = 1'b0;
  logic [8:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [NM-1:0]    req_valid = '0;
  logic [NM-1:0][31:0] req_addr = '0;
  logic [NM-1:0]    rsp_vld, rsp_err;
  logic [NM-1:0][3:0]  rsp_sel;
  logic [NM-1:0][31:0] rsp_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int unsigned sh_sel [NM][16];
  int unsigned sh_off [NM][16];
  int unsigned ac_sel [NM][16];
  int unsigned ac_off [NM][16];

  always #5 clk = ~clk;

  addr_remap #(.NUM_MST(NM)) u_addr_remap (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_vld_o(rsp_vld), .rsp_err_o(rsp_err), .rsp_sel_o(rsp_sel),
    .rsp_addr_o(rsp_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [27:0] lo_bits(input int m, input int a);
    return 28'((m * 32'h0123457 + a * 32'h00ABCDE) ^ 32'h05A5A5A);
  endfunction

  function automatic logic [31:0] pack(input int m, input int half, input bit is_off);
    logic [31:0] w = '0;
    for (int i = 0; i < 8; i++)
      w[4*i +: 4] = 4'(is_off ? sh_off[m][half*8+i] : sh_sel[m][half*8+i]);
    return w;
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [8:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic prog(input int m, input int ver);
    for (int a = 0; a < 16; a++) begin
      sh_sel[m][a] = (a * 3 + m + ver * 5) % 8;
      sh_off[m][a] = (a * 5 + m * 7 + ver * 3 + 1) % 16;
    end
    wr(9'(16*m + 0),  pack(m, 0, 0));
    wr(9'(16*m + 4),  pack(m, 1, 0));
    wr(9'(16*m + 8),  pack(m, 0, 1));
    wr(9'(16*m + 12), pack(m, 1, 1));
  endtask

  task automatic commit(input logic [31:0] mask);
    wr(9'h100, mask);
    for (int m = 0; m < NM; m++)
      if (mask[m])
        for (int a = 0; a < 16; a++) begin
          ac_sel[m][a] = sh_sel[m][a];
          ac_off[m][a] = sh_off[m][a];
        end
  endtask

  task automatic exp_chk(input int m, input int a, input string req);
    logic [37:0] got, exp;
    logic [3:0] es, eo;
    es = 4'(ac_sel[m][a]);
    eo = 4'(ac_off[m][a]);
    exp = {(es != 0), (es == 0), es, eo, lo_bits(m, a)};
    got = {rsp_vld[m], rsp_err[m], rsp_sel[m], rsp_addr[m]};
    chk(got == exp, req, 64'(got), 64'(exp));
  endtask

  task automatic drive_ap(input int a);
    req_valid = '1;
    for (int m = 0; m < NM; m++) req_addr[m] = {4'(a), lo_bits(m, a)};
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      drive_ap(a);
      @(negedge clk);
      req_valid = '0;
      for (int m = 0; m < NM; m++) exp_chk(m, a, req);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got %h exp %h", 64'(0), 64'(1));
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < NM; m++)
      for (int a = 0; a < 16; a++) begin
        sh_sel[m][a] = 0; sh_off[m][a] = 0; ac_sel[m][a] = 0; ac_off[m][a] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: outputs low after reset
    chk({rsp_vld, rsp_err} == '0 && rsp_addr == '0 && rsp_sel == '0, "R7 reset outputs",
        64'({rsp_vld, rsp_err}), 64'(0));
    rd_chk(9'h000, 32'h0, "R7 shadow reset");
    // R7: every aperture is a decode error before programming
    sweep("R7 reset tables");
    // R9: idle cycle gives no outcome
    @(negedge clk); req_valid = '0;
    @(negedge clk);
    chk({rsp_vld, rsp_err} == '0, "R9 idle", 64'({rsp_vld, rsp_err}), 64'(0));

    for (int m = 0; m < NM; m++) prog(m, 0);
    // R2 R8: readback of shadow words
    for (int m = 0; m < NM; m++)
      for (int w = 0; w < 4; w++)
        rd_chk(9'(16*m + 4*w), pack(m, w % 2, w >= 2), "R2 R8 readback");
    // R4: not committed yet
    sweep("R4 shadow only");
    // R5: partial commit, bits above NUM_MST ignored
    commit(32'hFFFF_FFF0 | 32'h5);
    sweep("R5 partial commit R10");
    commit(32'hA);
    sweep("R1 R3 full map");

    // R6: request in the commit cycle uses the old table
    prog(1, 1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 9'h100; reg_wdata = 32'h2;
    drive_ap(9);
    @(negedge clk);
    reg_we = 1'b0; req_valid = '0;
    for (int m = 0; m < NM; m++) exp_chk(m, 9, "R6 same-cycle commit");
    for (int a = 0; a < 16; a++) begin
      ac_sel[1][a] = sh_sel[1][a];
      ac_off[1][a] = sh_off[1][a];
    end
    sweep("R6 after commit R10");

    // R8: unmapped and update-register reads
    rd_chk(9'h100, 32'h0, "R8 update reads zero");
    rd_chk(9'h040, 32'h0, "R8 bank beyond masters");
    rd_chk(9'h1F0, 32'h0, "R8 high unmapped");
    wr(9'h044, 32'hDEAD_BEEF);
    wr(9'h1F4, 32'h1234_5678);
    rd_chk(9'h044, 32'h0, "R8 write beyond masters");
    for (int m = 0; m < NM; m++)
      for (int w = 0; w < 4; w++)
        rd_chk(9'(16*m + 4*w), pack(m, w % 2, w >= 2), "R8 banks untouched");
    sweep("R8 map untouched");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule